// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block sits beside a first-level data cache and watches the load stream. When a load misses, the block records it as a possible stream start. If later misses walk through consecutive cache lines in either direction, the candidate is confirmed. Once confirmed, every load that steps onto the next line of the stream produces two requests one cycle later. The first asks the first-level cache to fetch the following line. The second asks memory to place, in the second-level cache, the line twelve lines beyond the one just referenced.

Software can also hand the block a hint: a starting line, a direction and a line count. The hint creates a confirmed stream straight away. That stream stops by itself after the requested number of first-level prefetches. Several streams are tracked at once in a small table. When the table is full, a new stream takes the slot that was used least recently. A stream never follows lines past the edge of a 4 KB page.

Top module: `seq_prefetch_engine`

## Requirements
- R1: A miss on line A opens a candidate. A miss on A+1 then confirms the direction, and a miss on A+2 makes the stream steady. The A+2 miss is the first to issue a request: an L1 prefetch of A+3, registered one cycle after the load.
- R2: Before a stream is steady, only loads flagged as misses advance it. A non-miss load to the expected next line leaves the candidate or ramp state unchanged and issues nothing.
- R3: In a steady stream, any valid load (miss or not) to the next line in the stream direction gives l1_pf_valid one cycle later, with l1_pf_line equal to that load line plus one step in the stream direction. A repeat load to the line last referenced issues nothing. No request is issued in a cycle after one with no valid load.
- R4: Each L1 prefetch is accompanied in the same cycle by an L2 prefetch of the referenced line plus twelve lines in the stream direction.
- R5: Descending streams (A, A-1, A-2) are detected and prefetched in the same way, with negative steps.
- R6: A hint with a non-zero count installs a steady stream, ascending when hint_down is 0 and descending when it is 1. The first load to the hint line then issues prefetches at once, with no ramp.
- R7: A hinted stream issues exactly hint_count L1 prefetches and then ends. A hint with count 0 is ignored.
- R8: A page holds 32 lines (4 KB of 128-byte lines); pages are the line address bits above bit 4. If the L1 target lies in another page, nothing is issued and the stream ends. If only the L2 target lies in another page, the L1 request is issued without the L2 request.
- R9: Eight streams are tracked at once. When all are valid, a new stream replaces the least recently referenced one.
- R10: When hint_valid and ld_valid are high in the same cycle, the hint is taken and the load is ignored.
- R11: Synchronous reset drives both request outputs low and empties the stream table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load reference is presented |
| ld_miss | input | 1 | The load missed the L1 data cache |
| ld_line | input | LINE_W | Line address of the load |
| hint_valid | input | 1 | Software stream hint is presented |
| hint_down | input | 1 | Hint direction, 1 = descending |
| hint_line | input | LINE_W | First line of the hinted stream |
| hint_count | input | CNT_W | Number of lines to prefetch for the hint |
| l1_pf_valid | output | 1 | L1 prefetch request |
| l1_pf_line | output | LINE_W | Line for the L1 prefetch |
| l2_pf_valid | output | 1 | Memory-to-L2 prefetch request |
| l2_pf_line | output | LINE_W | Line for the L2 prefetch |

## Verification
The bench goes after the ramp boundary: a design that prefetched on the second miss, or let hits advance the ramp, would issue a request one step early. It walks hinted streams to their last line, where an off-by-one counter gives one request too many or too few. It puts streams at the last lines of a page, where a missing check would send requests into a foreign page. A final test fills all eight slots and re-touches the oldest one, so that first-in replacement instead of least-recent would evict the wrong stream.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
  typedef enum logic [1:0] {
    SLOT_CAND = 2'd0,
    SLOT_RAMP = 2'd1,
    SLOT_LIVE = 2'd2
  } slot_state_e;

  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_HINT  = 3'd1,
    ACT_STEP  = 3'd2,
    ACT_SAME  = 3'd3,
    ACT_ALLOC = 3'd4
  } pf_act_e;
endpackage

// File: rtl/pf_slot_match.sv
`timescale 1ns/1ps
module pf_slot_match
  import pf_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              valid,
  input  slot_state_e       state,
  input  logic              down,
  input  logic [LINE_W-1:0] cur,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              ld_miss,
  output logic              step_hit,
  output logic              same_hit,
  output logic              cand_down
);
  logic [LINE_W-1:0] up_line, dn_line, nxt_line;

  assign up_line   = cur + LINE_W'(1);
  assign dn_line   = cur - LINE_W'(1);
  assign nxt_line  = down ? dn_line : up_line;
  assign cand_down = (ld_line == dn_line);

  always_comb begin
    step_hit = 1'b0;
    if (valid) begin
      unique case (state)
        SLOT_CAND: step_hit = ld_miss && ((ld_line == up_line) || (ld_line == dn_line));
        SLOT_RAMP: step_hit = ld_miss && (ld_line == nxt_line);
        SLOT_LIVE: step_hit = (ld_line == nxt_line);
        default:   step_hit = 1'b0;
      endcase
    end
  end

  assign same_hit = valid && (ld_line == cur);
endmodule

// File: rtl/pf_lru.sv
`timescale 1ns/1ps
module pf_lru #(
  parameter int NUM_STREAMS = 8,
  localparam int IDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);
  logic [IDX_W-1:0] age [NUM_STREAMS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_STREAMS; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (IDX_W'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (age[i] == IDX_W'(NUM_STREAMS - 1)) lru_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pf_target.sv
`timescale 1ns/1ps
module pf_target #(
  parameter int LINE_W    = 26,
  parameter int PAGE_LOG2 = 5,
  parameter int L2_AHEAD  = 12
) (
  input  logic [LINE_W-1:0] ref_line,
  input  logic              down,
  output logic [LINE_W-1:0] l1_line,
  output logic              l1_ok,
  output logic [LINE_W-1:0] l2_line,
  output logic              l2_ok
);
  assign l1_line = down ? ref_line - LINE_W'(1) : ref_line + LINE_W'(1);
  assign l2_line = down ? ref_line - LINE_W'(L2_AHEAD) : ref_line + LINE_W'(L2_AHEAD);
  assign l1_ok   = (l1_line[LINE_W-1:PAGE_LOG2] == ref_line[LINE_W-1:PAGE_LOG2]);
  assign l2_ok   = (l2_line[LINE_W-1:PAGE_LOG2] == ref_line[LINE_W-1:PAGE_LOG2]);
endmodule

// File: rtl/seq_prefetch_engine.sv
`timescale 1ns/1ps
module seq_prefetch_engine
  import pf_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int NUM_STREAMS = 8,
  parameter int CNT_W       = 8,
  parameter int LINE_BYTES  = 128,
  parameter int PAGE_BYTES  = 4096,
  parameter int L2_AHEAD    = 12,
  localparam int IDX_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int PAGE_LOG2  = $clog2(PAGE_BYTES) - $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic              ld_miss,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              hint_valid,
  input  logic              hint_down,
  input  logic [LINE_W-1:0] hint_line,
  input  logic [CNT_W-1:0]  hint_count,
  output logic              l1_pf_valid,
  output logic [LINE_W-1:0] l1_pf_line,
  output logic              l2_pf_valid,
  output logic [LINE_W-1:0] l2_pf_line
);
  // stream table
  logic [NUM_STREAMS-1:0] s_valid, s_down, s_hint;
  slot_state_e            s_state [NUM_STREAMS];
  logic [LINE_W-1:0]      s_cur   [NUM_STREAMS];
  logic [CNT_W-1:0]       s_left  [NUM_STREAMS];

  logic [NUM_STREAMS-1:0] step_hit, same_hit, cand_down;
  logic [IDX_W-1:0]       step_idx, same_idx, free_idx, lru_idx, victim, act_idx;
  pf_act_e                act;
  logic [LINE_W-1:0]      t_l1_line, t_l2_line;
  logic                   t_l1_ok, t_l2_ok;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_match
    pf_slot_match #(.LINE_W(LINE_W)) u_match (
      .valid    (s_valid[g]),
      .state    (s_state[g]),
      .down     (s_down[g]),
      .cur      (s_cur[g]),
      .ld_line  (ld_line),
      .ld_miss  (ld_miss),
      .step_hit (step_hit[g]),
      .same_hit (same_hit[g]),
      .cand_down(cand_down[g])
    );
  end

  // lowest index wins among matching or free slots
  always_comb begin
    step_idx = '0;
    same_idx = '0;
    free_idx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (step_hit[i]) step_idx = IDX_W'(i);
      if (same_hit[i]) same_idx = IDX_W'(i);
      if (!s_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = (&s_valid) ? lru_idx : free_idx;

  always_comb begin
    act     = ACT_IDLE;
    act_idx = victim;
    if (hint_valid) begin
      if (hint_count != '0) act = ACT_HINT;
    end else if (ld_valid) begin
      if (|step_hit) begin
        act     = ACT_STEP;
        act_idx = step_idx;
      end else if (|same_hit) begin
        act     = ACT_SAME;
        act_idx = same_idx;
      end else if (ld_miss) begin
        act = ACT_ALLOC;
      end
    end
  end

  pf_lru #(.NUM_STREAMS(NUM_STREAMS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (act != ACT_IDLE),
    .touch_idx(act_idx),
    .lru_idx  (lru_idx)
  );

  pf_target #(
    .LINE_W   (LINE_W),
    .PAGE_LOG2(PAGE_LOG2),
    .L2_AHEAD (L2_AHEAD)
  ) u_target (
    .ref_line(ld_line),
    .down    (s_down[step_idx]),
    .l1_line (t_l1_line),
    .l1_ok   (t_l1_ok),
    .l2_line (t_l2_line),
    .l2_ok   (t_l2_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid     <= '0;
      s_down      <= '0;
      s_hint      <= '0;
      for (int i = 0; i < NUM_STREAMS; i++) begin
        s_state[i] <= SLOT_CAND;
        s_cur[i]   <= '0;
        s_left[i]  <= '0;
      end
      l1_pf_valid <= 1'b0;
      l1_pf_line  <= '0;
      l2_pf_valid <= 1'b0;
      l2_pf_line  <= '0;
    end else begin
      l1_pf_valid <= 1'b0;
      l2_pf_valid <= 1'b0;
      unique case (act)
        ACT_HINT: begin
          s_valid[act_idx] <= 1'b1;
          s_state[act_idx] <= SLOT_LIVE;
          s_down[act_idx]  <= hint_down;
          s_cur[act_idx]   <= hint_down ? hint_line + LINE_W'(1) : hint_line - LINE_W'(1);
          s_hint[act_idx]  <= 1'b1;
          s_left[act_idx]  <= hint_count;
        end
        ACT_STEP: begin
          s_cur[act_idx] <= ld_line;
          if (s_state[act_idx] == SLOT_CAND) begin
            s_state[act_idx] <= SLOT_RAMP;
            s_down[act_idx]  <= cand_down[act_idx];
          end else begin
            s_state[act_idx] <= SLOT_LIVE;
            if (!t_l1_ok) begin
              s_valid[act_idx] <= 1'b0;
            end else begin
              l1_pf_valid <= 1'b1;
              l1_pf_line  <= t_l1_line;
              l2_pf_valid <= t_l2_ok;
              l2_pf_line  <= t_l2_line;
              if (s_hint[act_idx]) begin
                s_left[act_idx] <= s_left[act_idx] - CNT_W'(1);
                if (s_left[act_idx] == CNT_W'(1)) s_valid[act_idx] <= 1'b0;
              end
            end
          end
        end
        ACT_ALLOC: begin
          s_valid[act_idx] <= 1'b1;
          s_state[act_idx] <= SLOT_CAND;
          s_down[act_idx]  <= 1'b0;
          s_cur[act_idx]   <= ld_line;
          s_hint[act_idx]  <= 1'b0;
          s_left[act_idx]  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_prefetch_engine_chk.sv
`timescale 1ns/1ps
module seq_prefetch_engine_chk #(
  parameter int LINE_W    = 26,
  parameter int PAGE_LOG2 = 5,
  parameter int L2_AHEAD  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic [LINE_W-1:0] ld_line,
  input logic              hint_valid,
  input logic              l1_pf_valid,
  input logic [LINE_W-1:0] l1_pf_line,
  input logic              l2_pf_valid,
  input logic [LINE_W-1:0] l2_pf_line
);
  // R3
  l1_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    l1_pf_valid |-> ((l1_pf_line == $past(ld_line) + LINE_W'(1)) ||
                     (l1_pf_line == $past(ld_line) - LINE_W'(1))));

  // R3
  no_load_no_pf_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_valid) |-> !l1_pf_valid);

  // R4
  l2_with_l1_chk: assert property (@(posedge clk) disable iff (rst)
    l2_pf_valid |-> l1_pf_valid);

  // R4
  l2_distance_chk: assert property (@(posedge clk) disable iff (rst)
    l2_pf_valid |-> ((l2_pf_line == l1_pf_line + LINE_W'(L2_AHEAD - 1)) ||
                     (l2_pf_line == l1_pf_line - LINE_W'(L2_AHEAD - 1))));

  // R8
  l1_same_page_chk: assert property (@(posedge clk) disable iff (rst)
    l1_pf_valid |-> (l1_pf_line[LINE_W-1:PAGE_LOG2] == $past(ld_line[LINE_W-1:PAGE_LOG2])));

  // R10
  hint_blocks_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(hint_valid) |-> !l1_pf_valid);
endmodule

bind seq_prefetch_engine seq_prefetch_engine_chk #(
  .LINE_W   (LINE_W),
  .PAGE_LOG2(PAGE_LOG2),
  .L2_AHEAD (L2_AHEAD)
) u_chk (.*);

// File: tb/seq_prefetch_engine_tb_top.sv
`timescale 1ns/1ps
module seq_prefetch_engine_tb_top;
  localparam int LW = 26;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0, ld_miss = 1'b0, hint_valid = 1'b0, hint_down = 1'b0;
  logic [LW-1:0] ld_line = '0, hint_line = '0;
  logic [CW-1:0] hint_count = '0;
  logic          l1_pf_valid, l2_pf_valid;
  logic [LW-1:0] l1_pf_line, l2_pf_line;
  int            errors = 0;
  int            checks = 0;

  always #4 clk = ~clk;

  seq_prefetch_engine dut_i (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_miss(ld_miss), .ld_line(ld_line),
    .hint_valid(hint_valid), .hint_down(hint_down), .hint_line(hint_line),
    .hint_count(hint_count),
    .l1_pf_valid(l1_pf_valid), .l1_pf_line(l1_pf_line),
    .l2_pf_valid(l2_pf_valid), .l2_pf_line(l2_pf_line)
  );

  typedef struct packed {
    logic          hv;
    logic          hd;
    logic [CW-1:0] hc;
    logic [LW-1:0] hl;
    logic          lv;
    logic          lm;
    logic [LW-1:0] ll;
    logic          x1v;
    logic [LW-1:0] x1;
    logic          x2v;
    logic [LW-1:0] x2;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h100, 1'b0,26'h0,  1'b0,26'h0,  4'd1},  // R1 open
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h101, 1'b0,26'h0,  1'b0,26'h0,  4'd1},  // R1 direction
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h102, 1'b1,26'h103,1'b1,26'h10E,4'd4},  // R1 R4 steady
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h103, 1'b1,26'h104,1'b1,26'h10F,4'd3},  // R3 hit advances
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h103, 1'b0,26'h0,  1'b0,26'h0,  4'd3},  // R3 same line
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h25F, 1'b0,26'h0,  1'b0,26'h0,  4'd5},  // R5
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h25E, 1'b0,26'h0,  1'b0,26'h0,  4'd5},  // R5
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h25D, 1'b1,26'h25C,1'b1,26'h251,4'd5},  // R5
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h300, 1'b0,26'h0,  1'b0,26'h0,  4'd2},  // R2
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h301, 1'b0,26'h0,  1'b0,26'h0,  4'd2},  // R2 hit ignored
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h301, 1'b0,26'h0,  1'b0,26'h0,  4'd2},  // R2
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h302, 1'b0,26'h0,  1'b0,26'h0,  4'd2},  // R2 hit ignored
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b1,26'h302, 1'b1,26'h303,1'b1,26'h30E,4'd2},  // R2
    '{1'b1,1'b0,8'd3,26'h400,1'b0,1'b0,26'h0,   1'b0,26'h0,  1'b0,26'h0,  4'd6},  // R6 install
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h400, 1'b1,26'h401,1'b1,26'h40C,4'd6},  // R6 no ramp
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h401, 1'b1,26'h402,1'b1,26'h40D,4'd7},  // R7
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h402, 1'b1,26'h403,1'b1,26'h40E,4'd7},  // R7 last
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h403, 1'b0,26'h0,  1'b0,26'h0,  4'd7},  // R7 ended
    '{1'b1,1'b0,8'd0,26'h500,1'b0,1'b0,26'h0,   1'b0,26'h0,  1'b0,26'h0,  4'd7},  // R7 zero count
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h500, 1'b0,26'h0,  1'b0,26'h0,  4'd7},  // R7 no stream
    '{1'b1,1'b0,8'd10,26'h51C,1'b0,1'b0,26'h0,  1'b0,26'h0,  1'b0,26'h0,  4'd8},  // R8
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h51C, 1'b1,26'h51D,1'b0,26'h0,  4'd8},  // R8 L2 off page
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h51D, 1'b1,26'h51E,1'b0,26'h0,  4'd8},  // R8
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h51E, 1'b1,26'h51F,1'b0,26'h0,  4'd8},  // R8
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h51F, 1'b0,26'h0,  1'b0,26'h0,  4'd8},  // R8 L1 off page
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h520, 1'b0,26'h0,  1'b0,26'h0,  4'd8},  // R8 ended
    '{1'b1,1'b1,8'd4,26'h6B0,1'b0,1'b0,26'h0,   1'b0,26'h0,  1'b0,26'h0,  4'd6},  // R6 descending
    '{1'b1,1'b0,8'd2,26'h700,1'b1,1'b0,26'h6B0, 1'b0,26'h0,  1'b0,26'h0,  4'd10}, // R10 both
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h6B0, 1'b1,26'h6AF,1'b1,26'h6A4,4'd10}, // R10 load was dropped
    '{1'b0,1'b0,8'd0,26'h0,  1'b1,1'b0,26'h700, 1'b1,26'h701,1'b1,26'h70C,4'd10}  // R10 hint taken
  };

  task automatic check_out(input logic x1v, input logic [LW-1:0] x1,
                           input logic x2v, input logic [LW-1:0] x2, input string tag);
    checks++;
    if ((l1_pf_valid !== x1v) || (x1v && l1_pf_line !== x1) ||
        (l2_pf_valid !== x2v) || (x2v && l2_pf_line !== x2)) begin
      errors++;
      $display("FAIL %s: got l1 %0b/%h l2 %0b/%h, expected l1 %0b/%h l2 %0b/%h",
               tag, l1_pf_valid, l1_pf_line, l2_pf_valid, l2_pf_line, x1v, x1, x2v, x2);
    end
  endtask

  task automatic step(input logic hv, input logic hd, input logic [CW-1:0] hc,
                      input logic [LW-1:0] hl, input logic lv, input logic lm,
                      input logic [LW-1:0] ll, input logic x1v, input logic [LW-1:0] x1,
                      input logic x2v, input logic [LW-1:0] x2, input string tag);
    @(negedge clk);
    hint_valid = hv; hint_down = hd; hint_count = hc; hint_line = hl;
    ld_valid = lv; ld_miss = lm; ld_line = ll;
    @(posedge clk);
    #2;
    check_out(x1v, x1, x2v, x2, tag);
    hint_valid = 1'b0; ld_valid = 1'b0; ld_miss = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check_out(1'b0, '0, 1'b0, '0, "R11");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].hv, VEC[i].hd, VEC[i].hc, VEC[i].hl, VEC[i].lv, VEC[i].lm, VEC[i].ll,
           VEC[i].x1v, VEC[i].x1, VEC[i].x2v, VEC[i].x2, $sformatf("R%0d", VEC[i].rq));
    end

    // R11: reset in mid run empties the table
    do_reset();
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h701, 1'b0, '0, 1'b0, '0, "R11");

    // R9: fill all eight slots, re-touch the first, then evict the least recent
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 8'd100, 26'h1000 + LW'(i * 'h40), 1'b0, 1'b0, '0,
           1'b0, '0, 1'b0, '0, "R9");
    end
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h1000, 1'b1, 26'h1001, 1'b1, 26'h100C, "R9");
    step(1'b1, 1'b0, 8'd100, 26'h2000, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R9");
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h1040, 1'b0, '0, 1'b0, '0, "R9");
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h1001, 1'b1, 26'h1002, 1'b1, 26'h100D, "R9");
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h2000, 1'b1, 26'h2001, 1'b1, 26'h200C, "R9");
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h1080, 1'b1, 26'h1081, 1'b1, 26'h108C, "R9");
    step(1'b0, 1'b0, 8'd0, '0, 1'b1, 1'b0, 26'h11C0, 1'b1, 26'h11C1, 1'b1, 26'h11CC, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule